// File: doc/BRIEF.md
# Switching Amplifier Mode and Protection Controller

This block is the digital sequencer that sits beside a two-channel switching power amplifier. It takes an active-low power-down request, an active-low silence request, an 8-bit die temperature code in degrees Celsius and one overcurrent flag per channel. From these it decides when the modulator runs, when the output bridge is released from high impedance, and when the bridge may switch. It also pulses a one-cycle strobe that starts the output soft-start ramp, and it drives three active-low fault indicators.

After power-down is released, the controller runs a fixed-length initialisation and then parks in a silent idle state. In that state the modulator runs but the bridge does not switch. Releasing silence waits a programmable number of cycles, then starts switching with the soft-start strobe. Requesting silence lets switching continue for a different, shorter delay before it stops. Temperature is watched by two comparators with hysteresis. The first raises a warning. The second forces a shutdown of the bridge, and recovery from it is automatic once the die has cooled. Any channel overcurrent stops the bridge at once and holds a latched fault. That fault clears only after a power-down pulse or a silence pulse.

Top module: `amp_mode_ctrl`

## Requirements
- R1: While `pwr_dn_n` is low, the outputs are as follows, and the block enters this state asynchronously when `pwr_dn_n` falls: `bridge_hiz`=1, `bridge_sw`=0, `mod_on`=0, `ramp_go`=0, and all three fault outputs are 1 (inactive).
- R2: After `pwr_dn_n` rises, `mod_on` goes to 1 exactly INIT_CYC+3 clock edges later. `bridge_sw` stays 0 while `quiet_n` is low.
- R3: In silent idle, a rise of `quiet_n` makes `bridge_sw` rise exactly UNMUTE_DLY+3 edges later. `ramp_go` is 1 for exactly that first switching cycle and is otherwise 0.
- R4: While switching, a fall of `quiet_n` makes `bridge_sw` fall exactly MUTE_DLY+3 edges later. The bridge never switches while silence remains requested.
- R5: `warn_n` goes to 0 once `die_temp` is strictly above WARN_T (135 is not enough; 136 is). It returns to 1 only once `die_temp` is strictly below RESTORE_T. Between the two values the output holds.
- R6: When `die_temp` is strictly above SHUT_T, `hot_n` goes to 0 one edge later and `bridge_sw` goes to 0 on the following edge. Shutdown overrides a standing request to play, and it holds while the temperature stays at or above RESTORE_T.
- R7: Once `die_temp` is strictly below RESTORE_T after a shutdown, `hot_n` and `warn_n` both return to 1 on the next edge. If `quiet_n` is high, switching restarts through the soft start: `bridge_sw` and `ramp_go` rise UNMUTE_DLY+2 edges after the cooling value is applied.
- R8: An overcurrent flag on any channel (`ocp_flag` bit 0 or bit 1) drives `ocp_n` to 0 and `bridge_sw` to 0 on the edge that samples it. Both stay there after the flag drops, and playback cannot restart.
- R9: Holding `quiet_n` low clears a latched overcurrent fault: `ocp_n` returns to 1 three edges after `quiet_n` falls. After that, a rise of `quiet_n` restarts switching as in R3.
- R10: A low pulse on `pwr_dn_n` clears a latched overcurrent fault at once. After the normal start-up the block plays again if `quiet_n` is high.
- R11: If `quiet_n` falls again while the soft-start wait is still running, the wait is abandoned and the bridge never switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| pwr_dn_n | input | 1 | Active-low power-down request, asynchronous |
| quiet_n | input | 1 | Active-low silence request, asynchronous |
| die_temp | input | 8 | Die temperature, unsigned degrees Celsius |
| ocp_flag | input | NCH | Overcurrent flag, one per channel, active high |
| mod_on | output | 1 | Modulator running |
| bridge_sw | output | 1 | Output bridge allowed to switch |
| bridge_hiz | output | 1 | Output bridge held in high impedance |
| ramp_go | output | 1 | One-cycle soft-start strobe |
| ocp_n | output | 1 | Latched overcurrent fault, active low |
| warn_n | output | 1 | Thermal warning, active low |
| hot_n | output | 1 | Thermal shutdown, active low |

## Verification
The bench builds the controller with INIT_CYC=20, UNMUTE_DLY=12 and MUTE_DLY=5, and keeps the default thresholds and two channels. The short cycle counts let every sequence complete many times within the run. These include start-up, soft start, a soft start abandoned mid-wait, delayed stop, shutdown and automatic restart, and both fault-clearing paths. Each edge count can then be checked exactly. The default thresholds put the boundary temperatures 135/136 and 119/120 inside an 8-bit code. A seeded random temperature walk across 100 to 170 then crosses all three thresholds repeatedly from both sides.

// File: rtl/amc_pkg.sv
package amc_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_INIT = 3'd1,
    ST_IDLE = 3'd2,
    ST_SOFT = 3'd3,
    ST_RUN  = 3'd4,
    ST_STOP = 3'd5,
    ST_HOT  = 3'd6
  } amc_state_e;

  function automatic int unsigned amc_max3(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/amc_sync.sv
module amc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= RST_VAL;
        else         sh_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= {STAGES{RST_VAL}};
        else         sh_q <= {sh_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/amc_hyst.sv
module amc_hyst #(
  parameter int unsigned W     = 8,
  parameter int unsigned SET_T = 135,
  parameter int unsigned CLR_T = 120
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] temp,
  output logic         flag
);

  localparam logic [W-1:0] SET_V = W'(SET_T);
  localparam logic [W-1:0] CLR_V = W'(CLR_T);

  logic flag_q, flag_d;
  logic above, below;

  assign above = temp > SET_V;
  assign below = temp < CLR_V;

  always_comb begin
    flag_d = flag_q;
    if (above)      flag_d = 1'b1;
    else if (below) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  AST_HYST_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!above && !below) |=> (flag == $past(flag))); // R5

  AST_HYST_SET: assert property (@(posedge clk) disable iff (!rst_n)
    above |=> flag); // R5

endmodule

// File: rtl/amc_ocp.sv
module amc_ocp #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ocp_flag,
  input  logic           quiet_req,
  output logic           latched,
  output logic           trip
);

  logic [NCH-1:0] ch_hit;
  logic           any_hit;
  logic           lat_q, lat_d;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      assign ch_hit[c] = ocp_flag[c];
    end
  endgenerate

  assign any_hit = |ch_hit;

  always_comb begin
    lat_d = lat_q;
    if (any_hit)        lat_d = 1'b1;
    else if (quiet_req) lat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= 1'b0;
    else        lat_q <= lat_d;
  end

  assign latched = lat_q;
  assign trip    = lat_q | any_hit;

  AST_OCP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && !quiet_req) |=> lat_q); // R8

  AST_OCP_CATCH: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |=> lat_q); // R8

endmodule

// File: rtl/amc_fsm.sv
module amc_fsm
  import amc_pkg::*;
#(
  parameter int unsigned INIT_CYC   = 2048,
  parameter int unsigned MUTE_DLY   = 123,
  parameter int unsigned UNMUTE_DLY = 418
) (
  input  logic clk,
  input  logic rst_n,
  input  logic play_req,
  input  logic fault_trip,
  input  logic shutdown,
  output logic bridge_sw,
  output logic bridge_hiz,
  output logic ramp_go,
  output logic mod_on
);

  localparam int unsigned MAXC = amc_max3(INIT_CYC, MUTE_DLY, UNMUTE_DLY);
  localparam int unsigned TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] INIT_LAST = TW'(INIT_CYC - 1);
  localparam logic [TW-1:0] STOP_LAST = TW'(MUTE_DLY - 1);
  localparam logic [TW-1:0] SOFT_LAST = TW'(UNMUTE_DLY - 1);

  amc_state_e    state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_en;
  logic          ramp_q, ramp_d;
  logic          may_play;

  assign may_play = play_req && !fault_trip;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:  state_d = ST_INIT;
      ST_INIT: if (tmr_q == INIT_LAST) state_d = ST_IDLE;
      ST_IDLE: begin
        if (shutdown)      state_d = ST_HOT;
        else if (may_play) state_d = ST_SOFT;
      end
      ST_SOFT: begin
        if (shutdown)                state_d = ST_HOT;
        else if (!may_play)          state_d = ST_IDLE;
        else if (tmr_q == SOFT_LAST) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (shutdown)        state_d = ST_HOT;
        else if (fault_trip) state_d = ST_IDLE;
        else if (!play_req)  state_d = ST_STOP;
      end
      ST_STOP: begin
        if (shutdown)                state_d = ST_HOT;
        else if (fault_trip)         state_d = ST_IDLE;
        else if (tmr_q == STOP_LAST) state_d = ST_IDLE;
      end
      ST_HOT: begin
        if (!shutdown) state_d = may_play ? ST_SOFT : ST_IDLE;
      end
      default: state_d = ST_OFF;
    endcase
  end

  assign tmr_en = (state_q == ST_INIT) || (state_q == ST_SOFT) || (state_q == ST_STOP);

  always_comb begin
    tmr_d = tmr_q;
    if (state_d != state_q) tmr_d = '0;
    else if (tmr_en)        tmr_d = tmr_q + 1'b1;
  end

  assign ramp_d = (state_d == ST_RUN) && (state_q != ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      tmr_q   <= '0;
      ramp_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      ramp_q  <= ramp_d;
    end
  end

  assign bridge_sw  = (state_q == ST_RUN) || (state_q == ST_STOP);
  assign bridge_hiz = !bridge_sw;
  assign ramp_go    = ramp_q;
  assign mod_on     = (state_q != ST_OFF) && (state_q != ST_INIT);

  AST_RAMP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_go |=> !ramp_go); // R3

  AST_START_NEEDS_PLAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bridge_sw) |-> $past(play_req)); // R3

  AST_HOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> !bridge_sw); // R6

  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_trip |=> !bridge_sw); // R8

endmodule

// File: rtl/amp_mode_ctrl.sv
module amp_mode_ctrl #(
  parameter int unsigned NCH        = 2,
  parameter int unsigned TEMP_W     = 8,
  parameter int unsigned WARN_T     = 135,
  parameter int unsigned SHUT_T     = 150,
  parameter int unsigned RESTORE_T  = 120,
  parameter int unsigned INIT_CYC   = 2048,
  parameter int unsigned MUTE_DLY   = 123,
  parameter int unsigned UNMUTE_DLY = 418,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              pwr_dn_n,
  input  logic              quiet_n,
  input  logic [TEMP_W-1:0] die_temp,
  input  logic [NCH-1:0]    ocp_flag,
  output logic              mod_on,
  output logic              bridge_sw,
  output logic              bridge_hiz,
  output logic              ramp_go,
  output logic              ocp_n,
  output logic              warn_n,
  output logic              hot_n
);

  logic rst_int_n;
  logic play_s;
  logic warn_f, hot_f;
  logic ocp_lat, ocp_trip;

  amc_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_rst_sync (
    .clk    (clk),
    .arst_n (pwr_dn_n),
    .d      (1'b1),
    .q      (rst_int_n)
  );

  amc_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_quiet_sync (
    .clk    (clk),
    .arst_n (pwr_dn_n),
    .d      (quiet_n),
    .q      (play_s)
  );

  amc_hyst #(.W(TEMP_W), .SET_T(WARN_T), .CLR_T(RESTORE_T)) u_warn (
    .clk   (clk),
    .rst_n (rst_int_n),
    .temp  (die_temp),
    .flag  (warn_f)
  );

  amc_hyst #(.W(TEMP_W), .SET_T(SHUT_T), .CLR_T(RESTORE_T)) u_hot (
    .clk   (clk),
    .rst_n (rst_int_n),
    .temp  (die_temp),
    .flag  (hot_f)
  );

  amc_ocp #(.NCH(NCH)) u_ocp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ocp_flag  (ocp_flag),
    .quiet_req (!play_s),
    .latched   (ocp_lat),
    .trip      (ocp_trip)
  );

  amc_fsm #(
    .INIT_CYC   (INIT_CYC),
    .MUTE_DLY   (MUTE_DLY),
    .UNMUTE_DLY (UNMUTE_DLY)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .play_req   (play_s),
    .fault_trip (ocp_trip),
    .shutdown   (hot_f),
    .bridge_sw  (bridge_sw),
    .bridge_hiz (bridge_hiz),
    .ramp_go    (ramp_go),
    .mod_on     (mod_on)
  );

  assign ocp_n  = !ocp_lat;
  assign warn_n = !warn_f;
  assign hot_n  = !hot_f;

  AST_HOT_IMPLIES_WARN: assert property (@(posedge clk) disable iff (!rst_int_n)
    !hot_n |-> !warn_n); // R6

  AST_OCP_BRIDGE_OFF: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ocp_n |-> !bridge_sw); // R8

  AST_NO_PLAY_WHILE_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!play_s && !bridge_sw) |=> !bridge_sw); // R4

endmodule

// File: tb/amp_mode_ctrl_test.sv
module amp_mode_ctrl_test;

  localparam int INIT_C = 20;
  localparam int MUTE_C = 5;
  localparam int SOFT_C = 12;
  localparam int WARN_T = 135;
  localparam int SHUT_T = 150;
  localparam int REST_T = 120;

  logic       clk;
  logic       pwr_dn_n, quiet_n;
  logic [7:0] die_temp;
  logic [1:0] ocp_flag;
  logic       mod_on, bridge_sw, bridge_hiz, ramp_go, ocp_n, warn_n, hot_n;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  amp_mode_ctrl #(
    .INIT_CYC   (INIT_C),
    .MUTE_DLY   (MUTE_C),
    .UNMUTE_DLY (SOFT_C)
  ) uut (
    .clk        (clk),
    .pwr_dn_n   (pwr_dn_n),
    .quiet_n    (quiet_n),
    .die_temp   (die_temp),
    .ocp_flag   (ocp_flag),
    .mod_on     (mod_on),
    .bridge_sw  (bridge_sw),
    .bridge_hiz (bridge_hiz),
    .ramp_go    (ramp_go),
    .ocp_n      (ocp_n),
    .warn_n     (warn_n),
    .hot_n      (hot_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit hyst_next(input bit cur, input int t, input int set_t, input int clr_t);
    if (t > set_t) return 1'b1;
    if (t < clr_t) return 1'b0;
    return cur;
  endfunction

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    bit warn_m, hot_m, seen;
    void'($urandom(32'd1337));
    pwr_dn_n = 1'b0; quiet_n = 1'b0; die_temp = 8'd25; ocp_flag = 2'b00;
    tick(3);
    // R1 reset state
    chk("R1 hiz", bridge_hiz, 1);
    chk("R1 sw", bridge_sw, 0);
    chk("R1 mod", mod_on, 0);
    chk("R1 ramp", ramp_go, 0);
    chk("R1 errs", {ocp_n, warn_n, hot_n}, 7);

    // R2 start-up length
    pwr_dn_n = 1'b1;
    tick(INIT_C + 2);
    chk("R2 mod before", mod_on, 0);
    tick(1);
    chk("R2 mod after", mod_on, 1);
    tick(5);
    chk("R2 idle silent", bridge_sw, 0);

    // R3 soft start
    quiet_n = 1'b1;
    tick(SOFT_C + 2);
    chk("R3 not yet", bridge_sw, 0);
    tick(1);
    chk("R3 sw", bridge_sw, 1);
    chk("R3 ramp", ramp_go, 1);
    tick(1);
    chk("R3 ramp single", ramp_go, 0);

    // R4 delayed stop
    quiet_n = 1'b0;
    tick(MUTE_C + 2);
    chk("R4 still on", bridge_sw, 1);
    tick(1);
    chk("R4 off", bridge_sw, 0);

    // R11 abort during soft start
    quiet_n = 1'b1;
    tick(4);
    quiet_n = 1'b0;
    seen = 0;
    for (int i = 0; i < SOFT_C + 10; i++) begin
      tick(1);
      if (bridge_sw || ramp_go) seen = 1;
    end
    chk("R11 aborted", seen, 0);

    // R5 boundaries
    die_temp = 8'd135; tick(1);
    chk("R5 at 135", warn_n, 1);
    die_temp = 8'd136; tick(1);
    chk("R5 at 136", warn_n, 0);
    die_temp = 8'd120; tick(1);
    chk("R5 hold 120", warn_n, 0);
    die_temp = 8'd119; tick(1);
    chk("R5 clear 119", warn_n, 1);

    // R5 R6 random walk, silence held
    warn_m = 0; hot_m = 0;
    for (int i = 0; i < 300; i++) begin
      int t;
      t = int'($urandom_range(170, 100));
      die_temp = 8'(t);
      warn_m = hyst_next(warn_m, t, WARN_T, REST_T);
      hot_m  = hyst_next(hot_m, t, SHUT_T, REST_T);
      tick(1);
      chk("R5 warn rand", warn_n, int'(!warn_m));
      chk("R6 hot rand", hot_n, int'(!hot_m));
      chk("R4 silent rand", bridge_sw, 0);
    end
    die_temp = 8'd25;
    tick(2);

    // R6 shutdown during play, R7 restart
    quiet_n = 1'b1;
    tick(SOFT_C + 3);
    chk("R3 play again", bridge_sw, 1);
    die_temp = 8'd151;
    tick(1);
    chk("R6 hot flag", hot_n, 0);
    tick(1);
    chk("R6 bridge off", bridge_sw, 0);
    die_temp = 8'd130;
    tick(20);
    chk("R6 priority", bridge_sw, 0);
    chk("R6 hold", hot_n, 0);
    die_temp = 8'd119;
    tick(1);
    chk("R7 clear", {warn_n, hot_n}, 3);
    tick(SOFT_C);
    chk("R7 wait", bridge_sw, 0);
    tick(1);
    chk("R7 restart", bridge_sw, 1);
    chk("R7 ramp", ramp_go, 1);

    // R8 overcurrent latch
    ocp_flag = 2'b01;
    tick(1);
    chk("R8 flag", ocp_n, 0);
    chk("R8 stop", bridge_sw, 0);
    ocp_flag = 2'b00;
    tick(30);
    chk("R8 latched", ocp_n, 0);
    chk("R8 no play", bridge_sw, 0);

    // R9 clear by silence pulse
    quiet_n = 1'b0;
    tick(2);
    chk("R9 not yet", ocp_n, 0);
    tick(1);
    chk("R9 cleared", ocp_n, 1);
    quiet_n = 1'b1;
    tick(SOFT_C + 3);
    chk("R9 resumes", bridge_sw, 1);

    // R10 clear by power-down pulse
    ocp_flag = 2'b10;
    tick(1);
    chk("R8 ch1", ocp_n, 0);
    ocp_flag = 2'b00;
    pwr_dn_n = 1'b0;
    #1;
    chk("R10 async clear", ocp_n, 1);
    chk("R1 async hiz", bridge_hiz, 1);
    tick(2);
    pwr_dn_n = 1'b1;
    tick(INIT_C + 3);
    chk("R10 mod", mod_on, 1);
    tick(SOFT_C);
    chk("R10 wait", bridge_sw, 0);
    tick(1);
    chk("R10 plays", bridge_sw, 1);
    chk("R10 no fault", ocp_n, 1);

    report();
  end

endmodule